// File: doc/BRIEF.md
# Frequency Window Detector

This block judges whether a recovered-clock oscillator runs slow, fast, or inside an acceptable band around a reference frequency. The reference clock is divided by a programmable factor to set a fixed measurement interval. The oscillator clock is prescaled by a fixed factor, and each prescaled period is carried into the reference domain as a toggle event. Those events are counted over the interval. When the interval ends, the count is compared with a lower and an upper bound, and the block reaches one of three verdicts.

A slow verdict produces a raise-frequency pulse, and a fast verdict produces a lower-frequency pulse. The pulse length is a programmable number of reference cycles, so a charge pump or loop filter can take it directly. The verdict also drives a mute select. While the frequency is outside the band, the select forces the phase-detector up/down path to zero. When the verdict is in-band, the phase-detector signals pass straight through. A one-cycle strobe marks each decision, and the event counter restarts at that strobe.

Top module: `freq_window_det`

## Requirements
- R1: While `rst` is high, and on the first cycle after reset, `rise_out`, `fall_out`, `window_strobe` and `pd_mute` are all 0. The verdict starts in-band, so the phase-detector inputs pass through.
- R2: With `ref_div` = n (n >= 2), `window_strobe` is high for exactly one reference cycle in every n.
- R3: One event is counted for every PRESCALE oscillator cycles. In steady state, a window of n reference cycles holds exactly as many events as fit in its duration.
- R4: When the count for a window is below `lo_bound`, the verdict is slow: `rise_out` pulses and `pd_mute` is 1.
- R5: When the count is above `hi_bound`, the verdict is fast: `fall_out` pulses and `pd_mute` is 1.
- R6: A count equal to either bound, or lying between them, gives the in-band verdict. In that case there is no pulse and `pd_mute` is 0.
- R7: A pulse is high for exactly `pulse_len` reference cycles, starting in the cycle where `window_strobe` is high. When `pulse_len` is 0, no pulse is emitted.
- R8: `rise_out` and `fall_out` are never high together.
- R9: While `pd_mute` is 1, `pd_up_out` and `pd_dn_out` are 0. While `pd_mute` is 0, they equal `pd_up_in` and `pd_dn_in`.
- R10: The verdict and `pd_mute` change only in a cycle where `window_strobe` rises, and hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 1 | Oscillator clock under measurement |
| ref_div | input | DIV_W | Window length in reference cycles (>= 2) |
| lo_bound | input | CNT_W | Lowest in-band count |
| hi_bound | input | CNT_W | Highest in-band count |
| pulse_len | input | PLEN_W | Correction pulse length in reference cycles |
| pd_up_in | input | 1 | Phase-detector up signal |
| pd_dn_in | input | 1 | Phase-detector down signal |
| rise_out | output | 1 | Raise-frequency pulse (oscillator slow) |
| fall_out | output | 1 | Lower-frequency pulse (oscillator fast) |
| pd_up_out | output | 1 | Gated phase-detector up |
| pd_dn_out | output | 1 | Gated phase-detector down |
| pd_mute | output | 1 | High while the verdict is out of band |
| window_strobe | output | 1 | One-cycle end-of-window marker |

## Verification
The hardest condition to reach from the ports is a count that lands exactly on a bound. With two unrelated clocks, the count usually wanders by one from window to window. The bench therefore runs the oscillator at a rational multiple of the reference period, so that every steady-state window holds a fixed, computable number of events. It then sweeps the window length over a range that walks the count across the lower bound, through both boundary values, and past the upper bound. A second sweep changes the oscillator period instead of the window length.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    VERD_OK   = 2'b00,
    VERD_SLOW = 2'b01,
    VERD_FAST = 2'b10
  } verdict_e;
endpackage

// File: rtl/fwd_prescaler.sv
module fwd_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic osc_clk,
  input  logic rst,
  output logic tgl
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic          rst_m, rst_s;
  logic [PW-1:0] pcnt;

  always_ff @(posedge osc_clk) begin
    rst_m <= rst;
    rst_s <= rst_m;
  end

  always_ff @(posedge osc_clk) begin
    if (rst_s) begin
      pcnt <= '0;
      tgl  <= 1'b0;
    end else if (pcnt == PW'(PRESCALE - 1)) begin
      pcnt <= '0;
      tgl  <= ~tgl;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fwd_event_sync.sv
module fwd_event_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_async,
  output logic ev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      ev    <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], tgl_async};
      ev    <= chain[STAGES] ^ chain[STAGES-1];
    end
  end
endmodule

// File: rtl/fwd_interval.sv
module fwd_interval #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_n,
  output logic             last
);
  logic [DIV_W-1:0] icnt;

  assign last = (icnt >= div_n - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       icnt <= '0;
    else if (last) icnt <= '0;
    else           icnt <= icnt + 1'b1;
  end
endmodule

// File: rtl/fwd_pulse.sv
module fwd_pulse #(
  parameter int PLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              active,
  input  logic [PLEN_W-1:0] len,
  output logic              busy
);
  logic [PLEN_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst)               pcnt <= '0;
    else if (load)         pcnt <= active ? len : '0;
    else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
  end

  assign busy = (pcnt != '0);
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
  import fwd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 8,
  parameter int PLEN_W   = 6,
  parameter int PRESCALE = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              osc_clk,
  input  logic [DIV_W-1:0]  ref_div,
  input  logic [CNT_W-1:0]  lo_bound,
  input  logic [CNT_W-1:0]  hi_bound,
  input  logic [PLEN_W-1:0] pulse_len,
  input  logic              pd_up_in,
  input  logic              pd_dn_in,
  output logic              rise_out,
  output logic              fall_out,
  output logic              pd_up_out,
  output logic              pd_dn_out,
  output logic              pd_mute,
  output logic              window_strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tgl, ev, win_last, pbusy;
  logic [CNT_W-1:0] ev_cnt, total;
  verdict_e         verdict_q, verdict_d;

  fwd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .osc_clk(osc_clk), .rst(rst), .tgl(tgl));

  fwd_event_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(ref_clk), .rst(rst), .tgl_async(tgl), .ev(ev));

  fwd_interval #(.DIV_W(DIV_W)) u_int (
    .clk(ref_clk), .rst(rst), .div_n(ref_div), .last(win_last));

  assign total = (ev && ev_cnt != CNT_MAX) ? ev_cnt + 1'b1 : ev_cnt;

  always_comb begin
    if (total < lo_bound)      verdict_d = VERD_SLOW;
    else if (total > hi_bound) verdict_d = VERD_FAST;
    else                       verdict_d = VERD_OK;
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      ev_cnt        <= '0;
      verdict_q     <= VERD_OK;
      window_strobe <= 1'b0;
    end else begin
      window_strobe <= win_last;
      if (win_last) begin
        ev_cnt    <= '0;
        verdict_q <= verdict_d;
      end else begin
        ev_cnt <= total;
      end
    end
  end

  fwd_pulse #(.PLEN_W(PLEN_W)) u_pulse (
    .clk(ref_clk), .rst(rst), .load(win_last),
    .active(verdict_d != VERD_OK), .len(pulse_len), .busy(pbusy));

  assign rise_out  = pbusy && (verdict_q == VERD_SLOW);
  assign fall_out  = pbusy && (verdict_q == VERD_FAST);
  assign pd_mute   = (verdict_q != VERD_OK);
  assign pd_up_out = pd_mute ? 1'b0 : pd_up_in;
  assign pd_dn_out = pd_mute ? 1'b0 : pd_dn_in;

  // R8
  a_r8_one_direction: assert property (@(posedge ref_clk) disable iff (rst)
    !(rise_out && fall_out));
  // R9
  a_r9_mute_zeroes_pd: assert property (@(posedge ref_clk) disable iff (rst)
    pd_mute |-> (!pd_up_out && !pd_dn_out));
  // R10
  a_r10_verdict_held: assert property (@(posedge ref_clk) disable iff (rst)
    !win_last |=> $stable(verdict_q));
  // R2
  a_r2_strobe_single: assert property (@(posedge ref_clk) disable iff (rst)
    window_strobe |=> !window_strobe);
  // R7
  a_r7_pulse_starts_on_strobe: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(pbusy) |-> window_strobe);
endmodule

// File: tb/freq_window_det_test.sv
`timescale 1ns/1ps
module freq_window_det_test;
  logic       ref_clk = 0, osc_clk = 0, rst = 1;
  logic [7:0] ref_div = 8'd40, lo_bound = 8'd14, hi_bound = 8'd16;
  logic [5:0] pulse_len = 6'd5;
  logic       pd_up_in = 1, pd_dn_in = 1;
  logic       rise_out, fall_out, pd_up_out, pd_dn_out, pd_mute, window_strobe;
  real        osc_half = 1.25;
  int         errors = 0, checks = 0, cyc = 0;

  freq_window_det uut (
    .ref_clk(ref_clk), .rst(rst), .osc_clk(osc_clk), .ref_div(ref_div),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .pulse_len(pulse_len),
    .pd_up_in(pd_up_in), .pd_dn_in(pd_dn_in), .rise_out(rise_out),
    .fall_out(fall_out), .pd_up_out(pd_up_out), .pd_dn_out(pd_dn_out),
    .pd_mute(pd_mute), .window_strobe(window_strobe));

  always #2.5 ref_clk = ~ref_clk;
  initial begin
    #0.3;
    forever #(osc_half) osc_clk = ~osc_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_strobe();
    @(negedge ref_clk);
    while (!window_strobe) @(negedge ref_clk);
  endtask

  // exp: 0 in band, 1 slow, 2 fast
  task automatic run_case(input int n, input real half, input int plen);
    int evs, exp, ups, dns;
    bit mute0, both;
    @(negedge ref_clk);
    ref_div = 8'(n); osc_half = half; pulse_len = 6'(plen);
    wait_strobe(); wait_strobe(); wait_strobe();
    evs = int'((n * 5.0) / (4.0 * 2.0 * half)); // R3
    exp = (evs < 14) ? 1 : (evs > 16) ? 2 : 0;
    mute0 = pd_mute;
    check(pd_mute == (exp != 0), (exp == 0) ? "R6 mute" : "R4/R5 mute", pd_mute, exp != 0);
    check(pd_up_out == (exp == 0) && pd_dn_out == (exp == 0), "R9 pd gate", pd_up_out, exp == 0);
    ups = 0; dns = 0; both = 0;
    for (int i = 0; i < n; i++) begin
      if (rise_out) ups++;
      if (fall_out) dns++;
      if (rise_out && fall_out) both = 1;
      if (pd_mute != mute0) both = 1;
      @(negedge ref_clk);
    end
    check(ups == ((exp == 1) ? plen : 0), "R4/R7 rise pulse", ups, (exp == 1) ? plen : 0);
    check(dns == ((exp == 2) ? plen : 0), "R5/R7 fall pulse", dns, (exp == 2) ? plen : 0);
    check(!both, "R8/R10 exclusive and held", both, 0);
    check(window_strobe == 1, "R2 strobe period", window_strobe, 1);
    @(negedge ref_clk);
    check(window_strobe == 0, "R2 strobe width", window_strobe, 0);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    check(!rise_out && !fall_out && !window_strobe && !pd_mute, "R1 reset outputs",
          {rise_out, fall_out, window_strobe, pd_mute}, 0);
    @(negedge ref_clk); rst = 0;
    @(negedge ref_clk);
    check(!rise_out && !fall_out && !pd_mute && pd_up_out, "R1 after reset",
          {rise_out, fall_out, pd_mute, pd_up_out}, 1);
    // sweep window length: count = n/2 walks 10..20 across bounds 14/16
    for (int n = 20; n <= 40; n += 2) run_case(n, 1.25, (n % 3) + 1);
    // sweep oscillator period at n=40: counts 20, 16, 10, 8
    run_case(40, 1.25, 7);
    run_case(40, 1.5625, 4);
    run_case(40, 2.5, 9);
    run_case(40, 3.125, 2);
    // zero pulse length: verdict still mutes but no pulse (R7)
    run_case(40, 2.5, 0);
    // pass-through follows inputs when in band (R9)
    run_case(32, 1.25, 3);
    pd_up_in = 0; pd_dn_in = 1;
    @(negedge ref_clk);
    check(pd_up_out == 0 && pd_dn_out == 1, "R9 follow inputs", {pd_up_out, pd_dn_out}, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule